// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic core of a small controller. It holds the accumulator and the program status byte. On each cycle where an operation is presented, it combines the accumulator with an operand and the stored carry, writes the result back to the accumulator, and updates the carry, auxiliary carry and overflow flags that the operation defines. Addition, subtraction with borrow, increment, decrement, bitwise logic, complement, the four rotates, nibble swap, decimal adjust, carry set and clear, a plain accumulator load and a status write are all provided.

The parity bit of the status byte is not captured per operation. It always reflects the current accumulator, so a status write cannot change it. The status byte also holds two user flags and a two-bit register-bank select, which is brought out separately for the register file. A combinational mask reports which of carry, auxiliary carry and overflow the presented opcode will rewrite.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator reads 00h and the status byte reads 00h. The status layout is bit 7 carry, bit 6 auxiliary carry, bit 5 user flag 0, bits 4:3 bank select, bit 2 overflow, bit 1 user flag 1, bit 0 parity.
- R2: Opcode 02h (add) and 03h (add plus carry) write A+operand(+carry) to the accumulator. Carry is set on a carry out of bit 7, auxiliary carry on a carry out of bit 3, and overflow when two same-signed operands give a result of the other sign.
- R3: Opcode 04h writes A-operand-carry. Carry is set on a borrow out of bit 7, auxiliary carry on a borrow out of bit 3, and overflow when operands of differing sign give a result whose sign differs from A.
- R4: Status bit 0 always equals the XOR of the accumulator bits, including after opcode 01h (load operand) and after opcode 11h (status write), whatever value is written to bit 0.
- R5: Opcodes 05h (increment) and 06h (decrement) wrap modulo 256 and leave status bits 7:1 unchanged.
- R6: Opcodes 07h AND, 08h OR, 09h XOR (with the operand) and 0Ah complement act bitwise and leave carry, auxiliary carry and overflow unchanged.
- R7: Opcodes 0Bh rotate left and 0Dh rotate right act within the accumulator. Opcodes 0Ch and 0Eh rotate left and right through carry: the old carry enters the vacated bit and the bit shifted out becomes the carry.
- R8: Opcode 0Fh exchanges the upper and lower nibbles of the accumulator.
- R9: Opcode 10h (decimal adjust) adds 06h when the low nibble exceeds 9 or auxiliary carry is set. It then adds 60h when the high nibble exceeds 9 or carry is set. Carry is set if either step overflows and is never cleared by this opcode.
- R10: Opcode 11h writes operand bits 7:1 into the status byte, and the bank select output equals status bits 4:3.
- R11: Opcodes 12h and 13h set and clear the carry only.
- R12: Output flag_upd is {carry, auxiliary carry, overflow}. It reads 111 for opcodes 02h, 03h, 04h and 11h, reads 100 for 0Ch, 0Eh, 10h, 12h and 13h, and reads 000 for all others.
- R13: When op_valid is low, or for opcode 00h or any opcode above 13h, the accumulator and the status byte hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute the presented opcode this cycle |
| op | input | 5 | Operation select |
| operand | input | 8 | Second operand, load value or status write value |
| acc_q | output | 8 | Accumulator |
| status_q | output | 8 | Status byte |
| bank_sel | output | 2 | Register bank select |
| flag_upd | output | 3 | Flags rewritten by the presented opcode |

## Verification
The parity tracking and the flag update can fall in the same cycle. Every arithmetic, rotate or adjust operation changes the accumulator, and with it the parity, in the same edge that rewrites carry or overflow. A status write tries to force the parity bit opposite to what the accumulator implies. The bench judges each such cycle by comparing the whole status byte with a hand-computed value, so a stale parity bit or a clobbered flag shows up in the same check.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [4:0] op,
  input  logic [7:0] operand,
  output logic [7:0] acc_q,
  output logic [7:0] status_q,
  output logic [1:0] bank_sel,
  output logic [2:0] flag_upd
);

  localparam logic [4:0] OP_NOP  = 5'h00;
  localparam logic [4:0] OP_LD   = 5'h01;
  localparam logic [4:0] OP_ADD  = 5'h02;
  localparam logic [4:0] OP_ADDC = 5'h03;
  localparam logic [4:0] OP_SUBB = 5'h04;
  localparam logic [4:0] OP_INC  = 5'h05;
  localparam logic [4:0] OP_DEC  = 5'h06;
  localparam logic [4:0] OP_AND  = 5'h07;
  localparam logic [4:0] OP_OR   = 5'h08;
  localparam logic [4:0] OP_XOR  = 5'h09;
  localparam logic [4:0] OP_CPL  = 5'h0A;
  localparam logic [4:0] OP_RL   = 5'h0B;
  localparam logic [4:0] OP_RLC  = 5'h0C;
  localparam logic [4:0] OP_RR   = 5'h0D;
  localparam logic [4:0] OP_RRC  = 5'h0E;
  localparam logic [4:0] OP_SWAP = 5'h0F;
  localparam logic [4:0] OP_DA   = 5'h10;
  localparam logic [4:0] OP_WRST = 5'h11;
  localparam logic [4:0] OP_SETC = 5'h12;
  localparam logic [4:0] OP_CLRC = 5'h13;

  logic       cy_q, ac_q, ov_q, uf0_q, uf1_q;
  logic [1:0] bank_q;

  logic       cin;
  logic [8:0] sum9, dif9;
  logic [4:0] sum_lo;
  logic       bor_lo;
  logic       da_lo, da_hi;
  logic [8:0] da1, da2;

  logic [7:0] acc_d;
  logic       cy_d, ac_d, ov_d, uf0_d, uf1_d;
  logic [1:0] bank_d;

  assign cin    = (op == OP_ADD) ? 1'b0 : cy_q;
  assign sum9   = {1'b0, acc_q} + {1'b0, operand} + {8'd0, cin};
  assign sum_lo = {1'b0, acc_q[3:0]} + {1'b0, operand[3:0]} + {4'd0, cin};
  assign dif9   = {1'b0, acc_q} - {1'b0, operand} - {8'd0, cy_q};
  assign bor_lo = {1'b0, acc_q[3:0]} < ({1'b0, operand[3:0]} + {4'd0, cy_q});

  assign da_lo  = (acc_q[3:0] > 4'd9) || ac_q;
  assign da1    = {1'b0, acc_q} + (da_lo ? 9'h006 : 9'h000);
  assign da_hi  = (da1[7:4] > 4'd9) || cy_q || da1[8];
  assign da2    = {1'b0, da1[7:0]} + (da_hi ? 9'h060 : 9'h000);

  always_comb begin
    acc_d  = acc_q;
    cy_d   = cy_q;
    ac_d   = ac_q;
    ov_d   = ov_q;
    uf0_d  = uf0_q;
    uf1_d  = uf1_q;
    bank_d = bank_q;
    if (op_valid) begin
      case (op)
        OP_LD:   acc_d = operand;
        OP_ADD, OP_ADDC: begin
          acc_d = sum9[7:0];
          cy_d  = sum9[8];
          ac_d  = sum_lo[4];
          ov_d  = (acc_q[7] == operand[7]) && (sum9[7] != acc_q[7]);
        end
        OP_SUBB: begin
          acc_d = dif9[7:0];
          cy_d  = dif9[8];
          ac_d  = bor_lo;
          ov_d  = (acc_q[7] != operand[7]) && (dif9[7] != acc_q[7]);
        end
        OP_INC:  acc_d = acc_q + 8'd1;
        OP_DEC:  acc_d = acc_q - 8'd1;
        OP_AND:  acc_d = acc_q & operand;
        OP_OR:   acc_d = acc_q | operand;
        OP_XOR:  acc_d = acc_q ^ operand;
        OP_CPL:  acc_d = ~acc_q;
        OP_RL:   acc_d = {acc_q[6:0], acc_q[7]};
        OP_RR:   acc_d = {acc_q[0], acc_q[7:1]};
        OP_RLC: begin
          acc_d = {acc_q[6:0], cy_q};
          cy_d  = acc_q[7];
        end
        OP_RRC: begin
          acc_d = {cy_q, acc_q[7:1]};
          cy_d  = acc_q[0];
        end
        OP_SWAP: acc_d = {acc_q[3:0], acc_q[7:4]};
        OP_DA: begin
          acc_d = da2[7:0];
          cy_d  = cy_q | da1[8] | da2[8];
        end
        OP_WRST: begin
          cy_d   = operand[7];
          ac_d   = operand[6];
          uf0_d  = operand[5];
          bank_d = operand[4:3];
          ov_d   = operand[2];
          uf1_d  = operand[1];
        end
        OP_SETC: cy_d = 1'b1;
        OP_CLRC: cy_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB, OP_WRST:       flag_upd = 3'b111;
      OP_RLC, OP_RRC, OP_DA, OP_SETC, OP_CLRC: flag_upd = 3'b100;
      default:                                 flag_upd = 3'b000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= 8'h00;
      cy_q   <= 1'b0;
      ac_q   <= 1'b0;
      ov_q   <= 1'b0;
      uf0_q  <= 1'b0;
      uf1_q  <= 1'b0;
      bank_q <= 2'b00;
    end else begin
      acc_q  <= acc_d;
      cy_q   <= cy_d;
      ac_q   <= ac_d;
      ov_q   <= ov_d;
      uf0_q  <= uf0_d;
      uf1_q  <= uf1_d;
      bank_q <= bank_d;
    end
  end

  assign status_q = {cy_q, ac_q, uf0_q, bank_q, ov_q, uf1_q, ^acc_q};
  assign bank_sel = bank_q;

  p_load_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_LD) |=> (status_q[0] == ^$past(operand)));

  p_incdec_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_INC || op == OP_DEC)) |=> $stable(status_q[7:1]));

  p_logic_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_CPL))
      |=> ($stable(status_q[7:6]) && $stable(status_q[2])));

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_SWAP) |=> (acc_q == {$past(acc_q[3:0]), $past(acc_q[7:4])}));

  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_ADD)
      |=> (status_q[7] == (({1'b0, $past(acc_q)} + {1'b0, $past(operand)}) > 9'd255)));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_q) && $stable(status_q)));

  p_da_keeps_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_DA && status_q[7]) |=> status_q[7]);

endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op = 5'h00;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc_q, status_q;
  logic [1:0] bank_sel;
  logic [2:0] flag_upd;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .operand(operand),
    .acc_q(acc_q), .status_q(status_q), .bank_sel(bank_sel), .flag_upd(flag_upd)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic run(input logic [4:0] o, input logic [7:0] d);
    @(negedge clk);
    op_valid = 1'b1; op = o; operand = d;
    @(negedge clk);
    op_valid = 1'b0; op = 5'h00; operand = 8'h00;
  endtask

  task automatic mask(input logic [4:0] o, input logic [2:0] exp);
    @(negedge clk);
    op = o;
    #0.5;
    chk("R12 flag_upd", {5'd0, flag_upd}, {5'd0, exp});
    op = 5'h00;
  endtask

  task automatic t_reset;
    chk("R1 acc reset", acc_q, 8'h00);
    chk("R1 status reset", status_q, 8'h00);
  endtask

  task automatic t_add;
    run(5'h01, 8'h7F);
    run(5'h02, 8'h01);
    chk("R2 add acc", acc_q, 8'h80);
    chk("R2 add ac/ov status", status_q, 8'h45);
    run(5'h01, 8'hFF);
    run(5'h02, 8'h01);
    chk("R2 add wrap acc", acc_q, 8'h00);
    chk("R2 add carry status", status_q, 8'hC0);
    run(5'h01, 8'h10);
    run(5'h03, 8'h20);
    chk("R2 addc acc", acc_q, 8'h31);
    chk("R2 addc status", status_q, 8'h01);
  endtask

  task automatic t_sub;
    run(5'h01, 8'h10);
    run(5'h04, 8'h01);
    chk("R3 subb acc", acc_q, 8'h0F);
    chk("R3 subb aux borrow", status_q, 8'h40);
    run(5'h12, 8'h00);
    chk("R11 setc", status_q, 8'hC0);
    run(5'h04, 8'h20);
    chk("R3 subb borrow acc", acc_q, 8'hEE);
    chk("R3 subb borrow status", status_q, 8'h80);
    run(5'h01, 8'h80);
    run(5'h13, 8'h00);
    chk("R11 clrc", status_q, 8'h01);
    run(5'h04, 8'h01);
    chk("R3 subb ov acc", acc_q, 8'h7F);
    chk("R3 subb ov status", status_q, 8'h45);
  endtask

  task automatic t_incdec;
    run(5'h01, 8'hFF);
    run(5'h05, 8'h00);
    chk("R5 inc wrap", acc_q, 8'h00);
    chk("R5 inc flags", status_q, 8'h44);
    run(5'h06, 8'h00);
    chk("R5 dec wrap", acc_q, 8'hFF);
    chk("R5 dec flags", status_q, 8'h44);
  endtask

  task automatic t_logic;
    run(5'h12, 8'h00);
    run(5'h07, 8'h0F);
    chk("R6 and", acc_q, 8'h0F);
    run(5'h08, 8'h30);
    chk("R6 or", acc_q, 8'h3F);
    run(5'h09, 8'hFF);
    chk("R6 xor", acc_q, 8'hC0);
    run(5'h0A, 8'h00);
    chk("R6 cpl", acc_q, 8'h3F);
    chk("R6 flags kept", status_q, 8'hC4);
    run(5'h09, 8'h01);
    chk("R4 parity odd after xor", status_q, 8'hC5);
  endtask

  task automatic t_rot;
    run(5'h01, 8'h81);
    run(5'h0B, 8'h00);
    chk("R7 rl", acc_q, 8'h03);
    run(5'h0D, 8'h00);
    chk("R7 rr", acc_q, 8'h81);
    chk("R7 rr flags", status_q, 8'hC4);
    run(5'h13, 8'h00);
    run(5'h0E, 8'h00);
    chk("R7 rrc acc", acc_q, 8'h40);
    chk("R7 rrc carry", status_q, 8'hC5);
    run(5'h0C, 8'h00);
    chk("R7 rlc acc", acc_q, 8'h81);
    chk("R7 rlc carry", status_q, 8'h44);
  endtask

  task automatic t_swap;
    run(5'h01, 8'hA5);
    run(5'h0F, 8'h00);
    chk("R8 swap", acc_q, 8'h5A);
  endtask

  task automatic t_da;
    run(5'h13, 8'h00);
    run(5'h01, 8'h29);
    run(5'h02, 8'h18);
    chk("R2 bcd add acc", acc_q, 8'h41);
    run(5'h10, 8'h00);
    chk("R9 da low adjust", acc_q, 8'h47);
    chk("R9 da status", status_q, 8'h40);
    run(5'h01, 8'h99);
    run(5'h02, 8'h01);
    chk("R2 bcd add status", status_q, 8'h00);
    run(5'h10, 8'h00);
    chk("R9 da both adjust", acc_q, 8'h00);
    chk("R9 da carry", status_q, 8'h80);
  endtask

  task automatic t_status;
    run(5'h11, 8'h19);
    chk("R10 wrst parity ignored R4", status_q, 8'h18);
    chk("R10 bank 3", {6'd0, bank_sel}, 8'h03);
    run(5'h11, 8'hA6);
    chk("R10 wrst flags", status_q, 8'hA6);
    chk("R10 bank 0", {6'd0, bank_sel}, 8'h00);
    run(5'h11, 8'h08);
    chk("R10 bank 1", {6'd0, bank_sel}, 8'h01);
    run(5'h01, 8'h07);
    chk("R4 parity after load", status_q, 8'h09);
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_valid = 1'b0; op = 5'h05; operand = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk("R13 idle acc", acc_q, 8'h07);
    chk("R13 idle status", status_q, 8'h09);
    run(5'h00, 8'h55);
    run(5'h1F, 8'h55);
    chk("R13 nop acc", acc_q, 8'h07);
    chk("R13 nop status", status_q, 8'h09);
  endtask

  task automatic t_mask;
    mask(5'h02, 3'b111);
    mask(5'h04, 3'b111);
    mask(5'h11, 3'b111);
    mask(5'h10, 3'b100);
    mask(5'h0C, 3'b100);
    mask(5'h12, 3'b100);
    mask(5'h07, 3'b000);
    mask(5'h05, 3'b000);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_incdec();
    t_logic();
    t_rot();
    t_swap();
    t_da();
    t_status();
    t_idle();
    t_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule